// File: doc/BRIEF.md
# Single-Channel DMA Engine with Byte/Word Sizing and Three Transfer Modes

This block is one DMA channel. Software programs a memory address, a transfer count and a control word through a small register port. Each pulse on the trigger input then moves one item. The channel reads the item from the current memory address and writes it to a fixed peripheral address, which is set by a parameter. Both accesses go through a single-beat bus-master port. The port holds its request until the slave acknowledges it.

The control word picks the item size (one byte or a two-byte word) and the direction in which the memory address steps (up or down). Two of its bits together choose one of three operating modes:
- **Single-pass mode** counts down once and then disables the channel.
- **Cyclic mode** restores the starting address and count at the end and keeps running.
- **Fixed-address mode** counts down once but never moves the memory address.

When the channel turns off and interrupts are allowed, an end-of-transfer interrupt is raised. It stays high until software next writes the control word.

Top module: `dma_channel`

## Requirements
- R1: Control bit 1 (`size`) selects byte items when 0 and word items when 1. Word accesses drive byte strobe `2'b11`. Byte accesses drive exactly one strobe bit.
- R2: Control bit 2 (`dir`) makes the memory address rise when 0 and fall when 1, after each item. The step is 1 for bytes and 2 for words.
- R3: The mode comes from control bit 3 (`rpt`) and bit 4 (`ie`). `rpt`=0 gives single-pass mode for either value of `ie`. `rpt`=1 with `ie`=0 gives cyclic mode. `rpt`=1 with `ie`=1 gives fixed-address mode.
- R4: In cyclic mode, the item that brings the count to zero restores the start address and the initial count (the values last written by software). The enable bit stays 1.
- R5: In fixed-address mode the memory address never changes. In single-pass and fixed-address modes, the enable bit (control bit 0) clears by itself when the count reaches zero.
- R6: Whenever the enable bit goes from 1 to 0 while `ie`=1, `irq_o` rises. This holds whether the bit was cleared by hardware or by a software write. `irq_o` stays 1 until the next write to the control register, unless that same write itself clears the enable bit with `ie`=1.
- R7: The register map is: index 0 = memory address, index 1 = count, index 2 = control. Control bits are: 0 en, 1 size, 2 dir, 3 rpt, 4 ie, and 5 the interrupt flag (read-only). Index 3 reads 0. After reset all registers read 0 and `irq_o` and `bus_req_o` are 0.
- R8: A word read goes to the memory address with bit 0 forced to 0. A byte read goes to the exact address, with strobe `2'b01` when the address is even and `2'b10` when it is odd.
- R9: A trigger is ignored, and starts no bus access, while the channel is disabled or while an item is still in flight.
- R10: Each item is one read at the memory address followed by one write to `PERIPH_ADDR`, each held until acknowledged. For words the written data equals the data read. For bytes the selected byte is copied onto both lanes. The write strobe follows R8 rules applied to `PERIPH_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data (combinational on index) |
| trigger_i | input | 1 | Request for one item |
| bus_req_o | output | 1 | Bus request, held until acknowledge |
| bus_we_o | output | 1 | 1 = write access, 0 = read access |
| bus_addr_o | output | ADDR_W | Bus byte address |
| bus_be_o | output | 2 | Byte strobes |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |
| irq_o | output | 1 | End-of-transfer interrupt |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:
- **Word transfer from an odd address while counting down.** A wrong design would issue a misaligned read, or step by 1 instead of 2.
- **Cyclic-mode wrap.** The bench sends one more item than the count. A broken reload would run off past the start address or drop the enable bit.
- **Fixed-address mode.** A design that decoded the mode bits wrongly would move the address, or leave the channel running without raising the interrupt.
- **Trigger while disabled and a second trigger during a live item.** Either one leaking through would produce an extra bus access and an extra count decrement.
- **Single-pass mode with `ie`=1.** This guards against confusing it with fixed-address mode.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {MODE_IO, MODE_RPT, MODE_IDLE} mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} bus_st_e;

  localparam logic [1:0] REG_MAR  = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_SIZE = 1;
  localparam int unsigned CB_DIR  = 2;
  localparam int unsigned CB_RPT  = 3;
  localparam int unsigned CB_IE   = 4;
  localparam int unsigned CB_IRQ  = 5;
  localparam int unsigned CTRL_W  = 5;

  function automatic mode_e decode_mode(input logic rpt, input logic ie);
    if (!rpt)    return MODE_IO;
    else if (ie) return MODE_IDLE;
    else         return MODE_RPT;
  endfunction
endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              hw_clr_i,
  output logic              en_o,
  output logic              size_o,
  output logic              dir_o,
  output logic              rpt_o,
  output logic              ie_o,
  output logic              irq_o
);
  logic en_q, size_q, dir_q, rpt_q, ie_q, irq_q;
  logic en_d, ie_d, irq_d;

  always_comb begin
    ie_d = we_i ? wdata_i[CB_IE] : ie_q;
    if (we_i)          en_d = wdata_i[CB_EN];
    else if (hw_clr_i) en_d = 1'b0;
    else               en_d = en_q;
    // set beats clear when one write both disables and acknowledges
    if (en_q && !en_d && ie_d) irq_d = 1'b1;
    else if (we_i)             irq_d = 1'b0;
    else                       irq_d = irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; size_q <= 1'b0; dir_q <= 1'b0;
      rpt_q <= 1'b0; ie_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ie_q  <= ie_d;
      irq_q <= irq_d;
      if (we_i) begin
        size_q <= wdata_i[CB_SIZE];
        dir_q  <= wdata_i[CB_DIR];
        rpt_q  <= wdata_i[CB_RPT];
      end
    end
  end

  assign en_o   = en_q;
  assign size_o = size_q;
  assign dir_o  = dir_q;
  assign rpt_o  = rpt_q;
  assign ie_o   = ie_q;
  assign irq_o  = irq_q;

  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ie_q);
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic              reload_i,
  input  logic              size_i,
  input  logic              dir_i,
  output logic [ADDR_W-1:0] mar_o
);
  logic [ADDR_W-1:0] mar_q, start_q, inc;

  assign inc = size_i ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q   <= '0;
      start_q <= '0;
    end else if (we_i) begin
      mar_q   <= wdata_i;
      start_q <= wdata_i;
    end else if (reload_i) begin
      mar_q <= start_q;
    end else if (step_i) begin
      mar_q <= dir_i ? mar_q - inc : mar_q + inc;
    end
  end

  assign mar_o = mar_q;
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             dec_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      init_q <= '0;
    end else if (we_i) begin
      cnt_q  <= wdata_i;
      init_q <= wdata_i;
    end else if (reload_i) begin
      cnt_q <= init_q;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] PERIPH_ADDR = '0,
  localparam int unsigned     BE_W        = 2,
  localparam int unsigned     DATA_W      = 8 * BE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              size_i,
  input  logic [ADDR_W-1:0] mar_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BE_W-1:0]   bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              done_o
);
  bus_st_e           state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] mem_a, per_a;
  logic [BE_W-1:0]   mem_be, per_be;
  logic [7:0]        lane;

  always_comb begin
    mem_a  = size_i ? {mar_i[ADDR_W-1:1], 1'b0} : mar_i;
    per_a  = size_i ? {PERIPH_ADDR[ADDR_W-1:1], 1'b0} : PERIPH_ADDR;
    mem_be = size_i ? 2'b11 : (mar_i[0] ? 2'b10 : 2'b01);
    per_be = size_i ? 2'b11 : (PERIPH_ADDR[0] ? 2'b10 : 2'b01);
    lane   = mar_i[0] ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)   state_d = ST_RD;
      ST_RD:   if (bus_ack_i) state_d = ST_WR;
      ST_WR:   if (bus_ack_i) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD && bus_ack_i)
        data_q <= size_i ? bus_rdata_i : {lane, lane};
    end
  end

  assign bus_req_o   = (state_q != ST_IDLE);
  assign bus_we_o    = (state_q == ST_WR);
  assign bus_addr_o  = bus_we_o ? per_a : mem_a;
  assign bus_be_o    = bus_we_o ? per_be : mem_be;
  assign bus_wdata_o = data_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_WR) && bus_ack_i;

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> bus_req_o);
  assert_rd_then_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_ack_i) |=> (bus_req_o && bus_we_o));
  assert_word_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && size_i) |-> (bus_be_o == 2'b11 && !bus_addr_o[0]));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 24,
  parameter int unsigned       CNT_W       = 16,
  parameter int unsigned       REG_W       = 32,
  parameter logic [ADDR_W-1:0] PERIPH_ADDR = ADDR_W'(24'h00F000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             trigger_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]       bus_be_o,
  output logic [15:0]      bus_wdata_o,
  input  logic [15:0]      bus_rdata_i,
  input  logic             bus_ack_i,
  output logic             irq_o
);
  logic              mar_we, cnt_we, ctrl_we;
  logic              en, size, dir, rpt, ie, irq;
  logic [ADDR_W-1:0] mar;
  logic [CNT_W-1:0]  cnt;
  logic              last, busy, done, start;
  logic              wrap, step, hw_clr;
  mode_e             mode;
  logic              unused_wdata;

  assign mar_we  = reg_we_i && (reg_addr_i == REG_MAR);
  assign cnt_we  = reg_we_i && (reg_addr_i == REG_CNT);
  assign ctrl_we = reg_we_i && (reg_addr_i == REG_CTRL);
  assign unused_wdata = ^reg_wdata_i;

  assign mode   = decode_mode(rpt, ie);
  assign start  = trigger_i && en && !busy;
  assign wrap   = done && last && (mode == MODE_RPT);
  assign step   = done && (mode != MODE_IDLE) && !wrap;
  assign hw_clr = done && last && (mode != MODE_RPT);

  dma_ctrl_regs i_ctrl (
    .clk_i, .rst_ni,
    .we_i     (ctrl_we),
    .wdata_i  (reg_wdata_i[CTRL_W-1:0]),
    .hw_clr_i (hw_clr),
    .en_o     (en),
    .size_o   (size),
    .dir_o    (dir),
    .rpt_o    (rpt),
    .ie_o     (ie),
    .irq_o    (irq)
  );

  dma_addr_unit #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i, .rst_ni,
    .we_i     (mar_we),
    .wdata_i  (reg_wdata_i[ADDR_W-1:0]),
    .step_i   (step),
    .reload_i (wrap),
    .size_i   (size),
    .dir_i    (dir),
    .mar_o    (mar)
  );

  dma_count_unit #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .we_i     (cnt_we),
    .wdata_i  (reg_wdata_i[CNT_W-1:0]),
    .dec_i    (done),
    .reload_i (wrap),
    .cnt_o    (cnt),
    .last_o   (last)
  );

  dma_bus_fsm #(.ADDR_W(ADDR_W), .PERIPH_ADDR(PERIPH_ADDR)) i_bus (
    .clk_i, .rst_ni,
    .start_i     (start),
    .size_i      (size),
    .mar_i       (mar),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_be_o    (bus_be_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ack_i   (bus_ack_i),
    .busy_o      (busy),
    .done_o      (done)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_MAR:  reg_rdata_o[ADDR_W-1:0] = mar;
      REG_CNT:  reg_rdata_o[CNT_W-1:0]  = cnt;
      REG_CTRL: begin
        reg_rdata_o[CB_EN]   = en;
        reg_rdata_o[CB_SIZE] = size;
        reg_rdata_o[CB_DIR]  = dir;
        reg_rdata_o[CB_RPT]  = rpt;
        reg_rdata_o[CB_IE]   = ie;
        reg_rdata_o[CB_IRQ]  = irq;
      end
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq;

  assert_rpt_keep_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && last && mode == MODE_RPT && !reg_we_i) |=> en);
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && mode == MODE_IDLE && !reg_we_i) |=> $stable(mar));
  assert_auto_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && last && mode != MODE_RPT && !reg_we_i) |=> !en);
  assert_trig_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && !en) |=> !bus_req_o);
endmodule

// File: tb/test_dma_channel.sv
module test_dma_channel;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] PER = 24'h00F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trigger = 1'b0;
  logic        bus_req, bus_we, bus_ack;
  logic [23:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  logic [23:0] rd_addr [64];
  logic [1:0]  rd_be   [64];
  logic [23:0] wr_addr [64];
  logic [1:0]  wr_be   [64];
  logic [15:0] wr_data [64];
  int n_rd = 0, n_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_channel i_dma_channel (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .trigger_i(trigger),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_be_o(bus_be), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack), .irq_o(irq)
  );

  function automatic logic [15:0] fmem(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[8:1] ^ 8'h3C};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req & ~bus_ack;
      bus_rdata <= fmem(bus_addr);
    end
  end

  always @(posedge clk) begin
    if (bus_req && bus_ack) begin
      if (bus_we) begin
        wr_addr[n_wr[5:0]] <= bus_addr;
        wr_be[n_wr[5:0]]   <= bus_be;
        wr_data[n_wr[5:0]] <= bus_wdata;
        n_wr <= n_wr + 1;
      end else begin
        rd_addr[n_rd[5:0]] <= bus_addr;
        rd_be[n_rd[5:0]]   <= bus_be;
        n_rd <= n_rd + 1;
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl(input bit en, sz, dr, rp, ie);
    return {27'd0, ie, rp, dr, sz, en};
  endfunction

  task automatic fire();
    int w0;
    w0 = n_wr;
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
    for (int i = 0; i < 20 && n_wr == w0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_item(input string tag, input int k, input logic [23:0] mar, input bit sz);
    logic [23:0] ea;
    logic [15:0] d;
    logic [7:0]  b;
    ea = sz ? {mar[23:1], 1'b0} : mar;
    d  = fmem(ea);
    b  = mar[0] ? d[15:8] : d[7:0];
    check({tag, " R8 read addr"}, 32'(rd_addr[k]), 32'(ea));
    check({tag, " R1 read strobe"}, 32'(rd_be[k]), sz ? 32'd3 : (mar[0] ? 32'd2 : 32'd1));
    check({tag, " R10 write addr"}, 32'(wr_addr[k]), 32'(PER));
    check({tag, " R10 write strobe"}, 32'(wr_be[k]), sz ? 32'd3 : 32'd1);
    check({tag, " R10 write data"}, 32'(wr_data[k]), sz ? 32'(d) : 32'({b, b}));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(2'd0, v); check("R7 reset mar", v, 0);
    rd_reg(2'd1, v); check("R7 reset count", v, 0);
    rd_reg(2'd2, v); check("R7 reset ctrl", v, 0);
    rd_reg(2'd3, v); check("R7 index3 zero", v, 0);
    check("R7 reset irq", 32'(irq), 0);
    check("R7 reset req", 32'(bus_req), 0);
  endtask

  task automatic t_io_byte_up();
    logic [31:0] v;
    int b0;
    b0 = n_wr;
    wr_reg(2'd0, 32'h100);
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd2, ctrl(1, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) fire();
    check("R2 byte up count of items", 32'(n_wr - b0), 3);
    for (int i = 0; i < 3; i++) check_item("byte up", b0 + i, 24'h100 + 24'(i), 0);
    rd_reg(2'd0, v); check("R2 byte up final mar", v, 32'h103);
    rd_reg(2'd1, v); check("R5 io count zero", v, 0);
    rd_reg(2'd2, v); check("R5 io auto clear en", v, ctrl(0, 0, 0, 0, 0));
    check("R6 no irq when ie=0", 32'(irq), 0);
  endtask

  task automatic t_word_down_odd();
    logic [31:0] v;
    int b0;
    b0 = n_wr;
    wr_reg(2'd0, 32'h209);
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd2, ctrl(1, 1, 1, 0, 0));
    fire(); fire();
    check_item("word down", b0, 24'h209, 1);
    check_item("word down", b0 + 1, 24'h207, 1);
    rd_reg(2'd0, v); check("R2 word down step 2", v, 32'h205);
    rd_reg(2'd2, v); check("R5 word io en cleared", v[0], 0);
  endtask

  task automatic t_repeat();
    logic [31:0] v;
    int b0;
    b0 = n_wr;
    wr_reg(2'd0, 32'h300);
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd2, ctrl(1, 0, 0, 1, 0));
    fire(); fire();
    rd_reg(2'd0, v); check("R4 repeat mar reloaded", v, 32'h300);
    rd_reg(2'd1, v); check("R4 repeat count reloaded", v, 2);
    rd_reg(2'd2, v); check("R3 R4 repeat stays enabled", v, ctrl(1, 0, 0, 1, 0));
    fire();
    check_item("repeat", b0 + 2, 24'h300, 0);
    rd_reg(2'd0, v); check("R4 repeat after wrap mar", v, 32'h301);
    rd_reg(2'd1, v); check("R4 repeat after wrap count", v, 1);
    check("R4 repeat no irq", 32'(irq), 0);
  endtask

  task automatic t_idle_mode();
    logic [31:0] v;
    int b0;
    b0 = n_wr;
    wr_reg(2'd0, 32'h400);
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd2, ctrl(1, 1, 0, 1, 1));
    fire();
    rd_reg(2'd0, v); check("R5 idle mar holds", v, 32'h400);
    check("R6 no irq while enabled", 32'(irq), 0);
    fire();
    check_item("idle", b0 + 1, 24'h400, 1);
    rd_reg(2'd0, v); check("R3 R5 idle mar still holds", v, 32'h400);
    rd_reg(2'd2, v); check("R5 R6 idle end ctrl", v, 32'h3A);
    check("R6 irq raised", 32'(irq), 1);
    @(negedge clk);
    check("R6 irq held", 32'(irq), 1);
    wr_reg(2'd2, ctrl(0, 0, 0, 0, 1));
    #1 check("R6 irq cleared by ctrl write", 32'(irq), 0);
  endtask

  task automatic t_io_with_ie();
    logic [31:0] v;
    wr_reg(2'd0, 32'h500);
    wr_reg(2'd1, 32'd1);
    wr_reg(2'd2, ctrl(1, 0, 1, 0, 1));
    fire();
    rd_reg(2'd0, v); check("R3 rpt=0 ie=1 is io, mar steps", v, 32'h4FF);
    check("R6 io end irq", 32'(irq), 1);
    wr_reg(2'd2, ctrl(1, 0, 0, 0, 1));
    #1 check("R6 enable write clears irq", 32'(irq), 0);
    wr_reg(2'd2, ctrl(0, 0, 0, 0, 1));
    #1 check("R6 software disable raises irq", 32'(irq), 1);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    int w0;
    wr_reg(2'd0, 32'h600);
    wr_reg(2'd1, 32'd5);
    wr_reg(2'd2, ctrl(0, 0, 0, 0, 0));
    w0 = n_wr;
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
    repeat (8) @(negedge clk);
    check("R9 disabled trigger no access", 32'(n_rd + n_wr - w0 - n_rd), 0);
    rd_reg(2'd1, v); check("R9 disabled trigger count kept", v, 5);
    wr_reg(2'd2, ctrl(1, 0, 0, 0, 0));
    w0 = n_wr;
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 busy trigger one item", 32'(n_wr - w0), 1);
    rd_reg(2'd1, v); check("R9 busy trigger count", v, 4);
    rd_reg(2'd0, v); check("R9 busy trigger mar", v, 32'h601);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io_byte_up();
    t_word_down_odd();
    t_repeat();
    t_idle_mode();
    t_io_with_ie();
    t_ignored();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule